// File: doc/BRIEF.md
# Multichannel Converter Frame Reader

This block is the host side of an SPI link to an eight-channel delta-sigma converter. When the converter's data-ready line falls, the reader pulls chip select low and clocks one data frame in. The frame holds a status word, the eight channel samples and a trailing checksum word, all of one word length. It then releases chip select and flags the end of the frame. The serial data-in line stays low for the whole frame, so the converter sees a null command. Reading a full frame after every data-ready event keeps the converter from skipping results. Skipping a result would halve the effective data rate.

Each received word is presented on a parallel output with a one-cycle valid strobe and an index giving its position in the frame. The word length is chosen at run time as 16, 24 or 32 bits. A second setting lets the reader stop after the last channel word, so the checksum word is never clocked. Both settings are captured when a frame starts. A data-ready edge that arrives while a frame is being read is reported on an overrun strobe and otherwise ignored.

Top module: `adc_frame_reader`

## Requirements
- R1: A falling edge on `drdy_n` while the reader is idle starts a frame. `spi_cs_n` goes low on the third rising clock edge after `drdy_n` is first sampled low: two synchronizer stages, then the state register.
- R2: A frame yields words with indices 0 through 9 in ascending order. Index 0 is the status word, indices 1 to 8 are channels 0 to 7, and index 9 is the checksum. With `cfg_skip_crc` = 1 the frame ends after index 8 and the checksum word is never clocked.
- R3: `cfg_wlen` sets the word length: 0 gives 16 bits, 1 gives 24 bits, 2 and 3 give 32 bits. A frame therefore has exactly words × length rising SCLK edges.
- R4: SPI mode 1 is used. `spi_sclk` idles low, has a period of CLK_DIV clocks with the high phase lasting CLK_DIV/2 clocks, and `spi_miso` is sampled on the falling edge, most significant bit first. Each word is right-justified in `word_data` with zeros above its length.
- R5: At least CLK_DIV clocks pass between `spi_cs_n` falling and the first SCLK rise. At least CLK_DIV clocks pass between the last SCLK fall and `spi_cs_n` rising.
- R6: `spi_mosi` is low whenever `spi_cs_n` is low.
- R7: `word_valid` is high for exactly one clock per received word, with `word_idx` and `word_data` valid in that cycle.
- R8: `frame_done` pulses for one clock, in the cycle in which `spi_cs_n` has just returned high.
- R9: A `drdy_n` falling edge during a frame produces a one-clock `overrun` pulse and does not restart or alter the frame. An edge while idle produces no `overrun`.
- R10: `cfg_wlen` and `cfg_skip_crc` are captured when a frame starts. Changing them during a frame has no effect on that frame.
- R11: After reset, `spi_cs_n` = 1 and `spi_sclk`, `spi_mosi`, `word_valid`, `frame_done` and `overrun` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wlen | input | 2 | Word length code (0: 16, 1: 24, 2/3: 32 bits) |
| cfg_skip_crc | input | 1 | 1 ends the frame after the last channel word |
| drdy_n | input | 1 | Converter data-ready, active low, asynchronous |
| spi_sclk | output | 1 | Serial clock, idles low |
| spi_cs_n | output | 1 | Chip select, active low |
| spi_mosi | output | 1 | Serial data to converter, held low |
| spi_miso | input | 1 | Serial data from converter |
| word_data | output | 32 | Received word, right-justified |
| word_idx | output | 4 | Position of the word in the frame (0 to 9) |
| word_valid | output | 1 | One-clock strobe per received word |
| frame_done | output | 1 | One-clock strobe at the end of a frame |
| overrun | output | 1 | One-clock strobe for a data-ready edge during a frame |

## Verification
Some properties are checked by assertions on every cycle:
- SCLK stays low while chip select is high.
- The valid strobe never lasts two cycles, and the index stays in range.
- The checksum index never appears when the skip setting is captured.
- `frame_done` coincides with chip select rising.
- The captured configuration holds for the whole frame.
- A mid-frame data-ready edge never sends the controller back to its lead-in phase.

Other properties only the bench scenarios can show:
- The received values and their bit order match what the converter model shifted out.
- The SCLK edge count matches the chosen word length.
- The lead-in and lead-out gaps are correct.
- A mid-frame configuration change or data-ready edge leaves the frame intact.

// File: rtl/afr_pkg.sv
package afr_pkg;

  localparam int unsigned WORD_MAX_W = 32;
  localparam int unsigned BITCNT_W   = 6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_LEAD  = 2'd1,
    ST_SHIFT = 2'd2,
    ST_TRAIL = 2'd3
  } afr_state_e;

  // Maps the word length code to a bit count: 0 -> 16, 1 -> 24, else 32.
  function automatic logic [BITCNT_W-1:0] wlen_bits(input logic [1:0] code);
    logic [BITCNT_W-1:0] n;
    case (code)
      2'd0:    n = BITCNT_W'(16);
      2'd1:    n = BITCNT_W'(24);
      default: n = BITCNT_W'(32);
    endcase
    return n;
  endfunction

endpackage

// File: rtl/afr_drdy_sync.sv
module afr_drdy_sync #(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic drdy_n_i,
  output logic fall_o
);

  logic [SYNC_STAGES-1:0] sync_q;
  logic                   last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      last_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], drdy_n_i};
      last_q <= sync_q[SYNC_STAGES-1];
    end
  end

  assign fall_o = last_q & ~sync_q[SYNC_STAGES-1];

  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall_o |=> !fall_o) else $error("edge strobe held");  // R1

endmodule

// File: rtl/afr_shift_in.sv
module afr_shift_in #(
  parameter int unsigned WORD_W = 32,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic              last_i,
  input  logic              miso_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [WORD_W-1:0] data_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              valid_o
);

  logic [WORD_W-1:0] shift_q;
  logic [WORD_W-1:0] shift_d;
  logic [WORD_W-1:0] word_next;

  assign word_next = {shift_q[WORD_W-2:0], miso_i};

  always_comb begin
    shift_d = shift_q;
    if (clr_i) begin
      shift_d = '0;
    end else if (sample_i) begin
      shift_d = last_i ? '0 : word_next;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
    end else if (clr_i || sample_i) begin
      shift_q <= shift_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_o  <= '0;
      idx_o   <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= sample_i & last_i;
      if (sample_i && last_i) begin
        data_o <= word_next;
        idx_o  <= idx_i;
      end
    end
  end

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o) else $error("word strobe held");  // R7

endmodule

// File: rtl/afr_sequencer.sv
module afr_sequencer
  import afr_pkg::*;
#(
  parameter int unsigned CLK_DIV   = 4,
  parameter int unsigned NUM_WORDS = 10,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic [1:0]       cfg_wlen_i,
  input  logic             cfg_skip_i,
  output logic             sclk_o,
  output logic             cs_n_o,
  output logic             clr_o,
  output logic             sample_o,
  output logic             last_bit_o,
  output logic [IDX_W-1:0] widx_o,
  output logic             done_o,
  output logic             ovr_o
);

  localparam int unsigned HALF = CLK_DIV / 2;
  localparam int unsigned PH_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam logic [PH_W-1:0]  PH_LAST    = PH_W'(CLK_DIV - 1);
  localparam logic [PH_W-1:0]  PH_FALL    = PH_W'(HALF - 1);
  localparam logic [IDX_W-1:0] IDX_FULL   = IDX_W'(NUM_WORDS - 1);
  localparam logic [IDX_W-1:0] IDX_SHORT  = IDX_W'(NUM_WORDS - 2);

  afr_state_e            state_q, state_d;
  logic [PH_W-1:0]       phase_q, phase_d;
  logic [BITCNT_W-1:0]   bit_q, bit_d;
  logic [IDX_W-1:0]      widx_q, widx_d;
  logic [BITCNT_W-1:0]   wbits_q;
  logic                  skip_q;
  logic                  sclk_q, sclk_d;
  logic                  cs_n_q, cs_n_d;
  logic                  done_q, done_d;
  logic                  ovr_q, ovr_d;
  logic                  cfg_load;
  logic                  bit_end;
  logic                  word_end;
  logic                  sample;

  assign bit_end  = (bit_q == BITCNT_W'(wbits_q - BITCNT_W'(1)));
  assign word_end = (widx_q == (skip_q ? IDX_SHORT : IDX_FULL));

  always_comb begin
    state_d  = state_q;
    phase_d  = phase_q;
    bit_d    = bit_q;
    widx_d   = widx_q;
    sclk_d   = sclk_q;
    cs_n_d   = cs_n_q;
    done_d   = 1'b0;
    ovr_d    = start_i && (state_q != ST_IDLE);
    cfg_load = 1'b0;
    sample   = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          state_d  = ST_LEAD;
          cs_n_d   = 1'b0;
          phase_d  = '0;
          bit_d    = '0;
          widx_d   = '0;
          cfg_load = 1'b1;
        end
      end
      ST_LEAD: begin
        if (phase_q == PH_LAST) begin
          state_d = ST_SHIFT;
          phase_d = '0;
          sclk_d  = 1'b1;
        end else begin
          phase_d = phase_q + 1'b1;
        end
      end
      ST_SHIFT: begin
        phase_d = phase_q + 1'b1;
        if (phase_q == PH_FALL) begin
          sclk_d = 1'b0;
          sample = 1'b1;
        end
        if (phase_q == PH_LAST) begin
          phase_d = '0;
          if (bit_end && word_end) begin
            state_d = ST_TRAIL;
          end else begin
            sclk_d = 1'b1;
            if (bit_end) begin
              bit_d  = '0;
              widx_d = widx_q + 1'b1;
            end else begin
              bit_d  = bit_q + 1'b1;
            end
          end
        end
      end
      ST_TRAIL: begin
        if (phase_q == PH_LAST) begin
          state_d = ST_IDLE;
          phase_d = '0;
          cs_n_d  = 1'b1;
          done_d  = 1'b1;
        end else begin
          phase_d = phase_q + 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      phase_q <= '0;
      bit_q   <= '0;
      widx_q  <= '0;
      sclk_q  <= 1'b0;
      cs_n_q  <= 1'b1;
      done_q  <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      phase_q <= phase_d;
      bit_q   <= bit_d;
      widx_q  <= widx_d;
      sclk_q  <= sclk_d;
      cs_n_q  <= cs_n_d;
      done_q  <= done_d;
      ovr_q   <= ovr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbits_q <= BITCNT_W'(16);
      skip_q  <= 1'b0;
    end else if (cfg_load) begin
      wbits_q <= wlen_bits(cfg_wlen_i);
      skip_q  <= cfg_skip_i;
    end
  end

  assign sclk_o     = sclk_q;
  assign cs_n_o     = cs_n_q;
  assign clr_o      = cfg_load;
  assign sample_o   = sample;
  assign last_bit_o = sample & bit_end;
  assign widx_o     = widx_q;
  assign done_o     = done_q;
  assign ovr_o      = ovr_q;

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_q |-> !sclk_q) else $error("sclk active without select");  // R4

  AST_DONE_AT_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |-> $rose(cs_n_q)) else $error("done not at release");  // R8

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && state_q == ST_SHIFT) |=> state_q != ST_LEAD) else $error("frame restarted");  // R9

  AST_SKIP_NO_CRC: assert property (@(posedge clk) disable iff (!rst_n)
    (sample && skip_q) |-> widx_q != IDX_FULL) else $error("checksum clocked");  // R2

  AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_IDLE && $past(state_q) != ST_IDLE) |-> ($stable(wbits_q) && $stable(skip_q)))
    else $error("config moved mid-frame");  // R10

endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader
  import afr_pkg::*;
#(
  parameter int unsigned CLK_DIV     = 4,
  parameter int unsigned NUM_CH      = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned NUM_WORDS  = NUM_CH + 2,
  localparam int unsigned IDX_W      = $clog2(NUM_WORDS)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            cfg_wlen,
  input  logic                  cfg_skip_crc,
  input  logic                  drdy_n,
  output logic                  spi_sclk,
  output logic                  spi_cs_n,
  output logic                  spi_mosi,
  input  logic                  spi_miso,
  output logic [WORD_MAX_W-1:0] word_data,
  output logic [IDX_W-1:0]      word_idx,
  output logic                  word_valid,
  output logic                  frame_done,
  output logic                  overrun
);

  logic             drdy_fall;
  logic             clr;
  logic             sample;
  logic             last_bit;
  logic [IDX_W-1:0] cur_idx;

  afr_drdy_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .drdy_n_i (drdy_n),
    .fall_o   (drdy_fall)
  );

  afr_sequencer #(
    .CLK_DIV   (CLK_DIV),
    .NUM_WORDS (NUM_WORDS),
    .IDX_W     (IDX_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (drdy_fall),
    .cfg_wlen_i (cfg_wlen),
    .cfg_skip_i (cfg_skip_crc),
    .sclk_o     (spi_sclk),
    .cs_n_o     (spi_cs_n),
    .clr_o      (clr),
    .sample_o   (sample),
    .last_bit_o (last_bit),
    .widx_o     (cur_idx),
    .done_o     (frame_done),
    .ovr_o      (overrun)
  );

  afr_shift_in #(
    .WORD_W (WORD_MAX_W),
    .IDX_W  (IDX_W)
  ) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (clr),
    .sample_i (sample),
    .last_i   (last_bit),
    .miso_i   (spi_miso),
    .idx_i    (cur_idx),
    .data_o   (word_data),
    .idx_o    (word_idx),
    .valid_o  (word_valid)
  );

  assign spi_mosi = 1'b0;

  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> word_idx <= IDX_W'(NUM_WORDS - 1)) else $error("index out of range");  // R2

  AST_VALID_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    word_valid |-> !spi_cs_n) else $error("word outside frame");  // R7

endmodule

// File: tb/tb_adc_frame_reader.sv
`timescale 1ns/1ps
module tb_adc_frame_reader;

  localparam int CLK_DIV = 4;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  cfg_wlen;
  logic        cfg_skip_crc;
  logic        drdy_n;
  logic        spi_sclk, spi_cs_n, spi_mosi, spi_miso;
  logic [31:0] word_data;
  logic [3:0]  word_idx;
  logic        word_valid, frame_done, overrun;

  always #2.5 clk = ~clk;

  adc_frame_reader #(.CLK_DIV(CLK_DIV)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_wlen(cfg_wlen), .cfg_skip_crc(cfg_skip_crc),
    .drdy_n(drdy_n), .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .word_data(word_data), .word_idx(word_idx),
    .word_valid(word_valid), .frame_done(frame_done), .overrun(overrun)
  );

  int checks = 0;
  int fails  = 0;
  int f_cur  = 0;
  int wb_cur = 16;
  int ptr    = 0;
  int exp_idx, lead, low_run, trail, mosi_bad, high_run, high_bad, done_cnt, ovr_cnt;
  bit seen_rise, prev_cs, done_bad;

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  function automatic logic [31:0] exp_word(input int f, input int idx, input int wb);
    logic [31:0] h;
    h = 32'h5A3C_96E1 ^ (32'(f) * 32'h0100_0193) ^ (32'(idx + 1) * 32'h9E37_79B1);
    h = h ^ (h >> 13);
    if (wb < 32) h = h & ((32'h1 << wb) - 32'h1);
    return h;
  endfunction

  function automatic int code_bits(input logic [1:0] c);
    return (c == 2'd0) ? 16 : (c == 2'd1) ? 24 : 32;
  endfunction

  // Converter model: shifts on rising SCLK, MSB first.
  initial begin
    spi_miso = 1'b0;
    forever begin
      @(negedge spi_cs_n);
      ptr = 0;
    end
  end
  initial begin
    forever begin
      @(posedge spi_sclk);
      begin
        int w, b;
        w = ptr / wb_cur;
        b = wb_cur - 1 - (ptr % wb_cur);
        spi_miso = (w < 10) ? exp_word(f_cur, w, wb_cur)[b] : 1'b0;
        ptr++;
      end
    end
  end

  // Monitor, sampled away from the active edge.
  initial begin
    prev_cs = 1'b1;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (word_valid) begin
          check(word_idx == 4'(exp_idx), "R7 index order", word_idx, exp_idx);
          check(word_data == exp_word(f_cur, exp_idx, wb_cur), "R4 word data",
                word_data, exp_word(f_cur, exp_idx, wb_cur));
          exp_idx++;
        end
        if (!spi_cs_n && spi_mosi) mosi_bad++;
        if (!spi_cs_n && !seen_rise && !spi_sclk) lead++;
        if (spi_sclk) begin
          seen_rise = 1'b1;
          low_run = 0;
          high_run++;
        end else begin
          if (high_run != 0 && high_run != CLK_DIV / 2) high_bad++;
          high_run = 0;
          if (!spi_cs_n && seen_rise) low_run++;
        end
        if (spi_cs_n && !prev_cs) trail = low_run;
        if (frame_done) begin
          done_cnt++;
          if (!(spi_cs_n && !prev_cs)) done_bad = 1'b1;
        end
        if (overrun) ovr_cnt++;
        prev_cs = spi_cs_n;
      end
    end
  end

  task automatic finish_up;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_up();
  end

  task automatic run_frame(input int f, input logic [1:0] code, input bit skip,
                           input bit mid_drdy, input bit mid_cfg);
    int words, guard;
    f_cur = f; wb_cur = code_bits(code);
    cfg_wlen = code; cfg_skip_crc = skip;
    exp_idx = 0; lead = 0; low_run = 0; trail = 0; mosi_bad = 0;
    high_run = 0; high_bad = 0; done_cnt = 0; ovr_cnt = 0;
    seen_rise = 1'b0; done_bad = 1'b0;
    words = skip ? 9 : 10;
    @(negedge clk);
    drdy_n = 1'b0;
    @(negedge clk);
    check(spi_cs_n == 1'b1, "R1 select before sync", spi_cs_n, 1);
    @(negedge clk);
    check(spi_cs_n == 1'b1, "R1 select before sync", spi_cs_n, 1);
    @(negedge clk);
    check(spi_cs_n == 1'b0, "R1 select after edge", spi_cs_n, 0);
    repeat (4) @(negedge clk);
    drdy_n = 1'b1;
    if (mid_cfg) begin
      cfg_wlen = ~code;
      cfg_skip_crc = ~skip;
    end
    if (mid_drdy) begin
      repeat (200) @(negedge clk);
      drdy_n = 1'b0;
      repeat (6) @(negedge clk);
      drdy_n = 1'b1;
    end
    guard = 0;
    while (done_cnt == 0 && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    repeat (60) @(negedge clk);
    check(exp_idx == words, "R2 word count", exp_idx, words);
    check(ptr == words * wb_cur, "R3 sclk edge count", ptr, words * wb_cur);
    check(lead >= CLK_DIV, "R5 lead gap", lead, CLK_DIV);
    check(trail >= CLK_DIV, "R5 trail gap", trail, CLK_DIV);
    check(mosi_bad == 0, "R6 mosi low", mosi_bad, 0);
    check(high_bad == 0, "R4 sclk high phase", high_bad, 0);
    check(done_cnt == 1 && !done_bad, "R8 done strobe", done_cnt, 1);
    check(ovr_cnt == (mid_drdy ? 1 : 0), "R9 overrun", ovr_cnt, mid_drdy ? 1 : 0);
    check(spi_cs_n == 1'b1, "R9 no restart", spi_cs_n, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    drdy_n = 1'b1;
    cfg_wlen = 2'd0;
    cfg_skip_crc = 1'b0;
    repeat (4) @(negedge clk);
    check(spi_cs_n == 1'b1, "R11 reset select", spi_cs_n, 1);
    check(spi_sclk == 1'b0 && spi_mosi == 1'b0, "R11 reset sclk/mosi", {spi_sclk, spi_mosi}, 0);
    check(!word_valid && !frame_done && !overrun, "R11 reset strobes",
          {word_valid, frame_done, overrun}, 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      for (int s = 0; s < 2; s++) begin
        run_frame(c * 2 + s + 1, 2'(c), s[0], 1'b0, 1'b0);
      end
    end
    run_frame(20, 2'd1, 1'b0, 1'b1, 1'b0);  // R9 mid-frame data-ready
    run_frame(21, 2'd0, 1'b1, 1'b0, 1'b1);  // R10 mid-frame config change
    run_frame(22, 2'd2, 1'b0, 1'b1, 1'b1);  // R9 and R10 together
    finish_up();
  end

endmodule